// File: doc/BRIEF.md
# Ping-Pong Input Capture

This block timestamps transitions on a single input line. Two capture circuits watch the same line and share one arm control. Each circuit has its own polarity selector. When a circuit fires, it copies the free-running timer value into its own small FIFO. Software, or a DMA engine, drains each FIFO through a pop strobe. While it drains, it sees the head word, the word count, a watermark flag and a sticky overflow flag.

With both circuits enabled, the circuits take turns. Circuit 0 goes first after arming, then circuit 1, then circuit 0 again. In free-running mode this alternation never stops. In one-shot mode the block drops its own arm bit once the last enabled circuit has captured. This makes it easy to measure a single pulse width or period.

An alternate source mode takes captures from a pre-qualified, clock-synchronous event strobe instead of the raw line. In that mode the edge polarity is bypassed.

Top module: `ping_pong_capture`

## Requirements
- R1: After reset, `arm_o` is 0, both word counts are 0, and both watermark and overflow flags are 0.
- R2: Each circuit's 2-bit edge code selects what it captures: 2'b00 nothing, 2'b01 falling edges, 2'b10 rising edges, 2'b11 either edge. `sig_i` passes through a two-flop synchronizer. The captured word is the value of `timer_i` at the third rising clock edge that sees the new `sig_i` level.
- R3: With both circuits enabled and armed, the first qualifying event goes to circuit 0, the next to circuit 1, and so on alternately. A circuit ignores events while it is not the one armed.
- R4: In one-shot mode with both circuits enabled, the capture by circuit 1 clears `arm_o`. Later events are not captured until the block is armed again.
- R5: With only one circuit enabled in free-running mode, every qualifying event is captured by that circuit, and `arm_o` stays 1.
- R6: With only one circuit enabled in one-shot mode, exactly one capture is taken and then `arm_o` clears.
- R7: When `ctrl_alt_sel` is 1, every `alt_evt_i` high cycle is a qualifying event, and `sig_i` edges are ignored. A circuit whose edge code is 2'b00 still never captures.
- R8: A control write with `ctrl_arm`=0 stops all captures. It also resets the turn order, so the next capture after re-arming goes to circuit 0.
- R9: Each FIFO holds 4 words and pops its head on `pop_i[k]`. A capture into a full FIFO is dropped and sets `ovf_o[k]`. That flag stays set until the next control write.
- R10: `wm_o[k]` is 1 exactly when circuit k's word count is greater than the `ctrl_wmark` value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe; loads all ctrl_* fields |
| ctrl_arm | input | 1 | Arm value written |
| ctrl_oneshot | input | 1 | 1 = one-shot, 0 = free-running |
| ctrl_edge0 | input | 2 | Edge code of circuit 0 |
| ctrl_edge1 | input | 2 | Edge code of circuit 1 |
| ctrl_alt_sel | input | 1 | 1 = capture on alt_evt_i |
| ctrl_wmark | input | 2 | Watermark threshold |
| timer_i | input | 16 | Free-running timer value |
| sig_i | input | 1 | Raw asynchronous input line |
| alt_evt_i | input | 1 | Synchronous pre-qualified event strobe |
| pop_i | input | 2 | Per-circuit FIFO pop |
| arm_o | output | 1 | Current arm state |
| head0_o | output | 16 | Head word of FIFO 0 |
| head1_o | output | 16 | Head word of FIFO 1 |
| cnt0_o | output | 3 | Word count of FIFO 0 |
| cnt1_o | output | 3 | Word count of FIFO 1 |
| wm_o | output | 2 | Per-circuit watermark flag |
| ovf_o | output | 2 | Per-circuit sticky overflow flag |

## Verification
The assertions assume a few things about the inputs:
- `alt_evt_i` is already synchronous to `clk`.
- Software does not expect a capture in the same cycle as a control write, because the write takes priority.
- Pops are only issued when a word is present.

The stimulus holds each timer value and line level for four clocks, so every synchronized edge lands clear of any control write. It raises an alternate event for exactly one cycle. It drains the FIFOs only through a monitor that pops after it has seen a nonzero count.

// File: rtl/cap_pkg.sv
// Shared types and helpers for the ping-pong capture block.
// Assumes edge codes are two bits wide.
package cap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    // Does a detected transition match the selected polarity?
    function automatic logic edge_match(edge_sel_e sel, logic rise, logic fall);
        case (sel)
            EDGE_FALL: edge_match = fall;
            EDGE_RISE: edge_match = rise;
            EDGE_ANY:  edge_match = rise | fall;
            default:   edge_match = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cap_sync_edge.sv
// Synchronizer plus edge detector for an asynchronous line.
// STAGES flops resynchronize din. One more flop holds the previous
// synchronized level. rise/fall are single-cycle pulses.
module cap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    // Shift the line through the synchronizer and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/cap_seq.sv
// Arm and turn sequencer for the two capture circuits.
// When both circuits are enabled, the one selected by 'turn' is armed.
// A single enabled circuit is always the armed one. A control write
// takes priority over a capture in the same cycle.
module cap_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       ctrl_arm,
    input  logic       oneshot,
    input  logic [1:0] en,
    input  logic [1:0] hit,
    output logic       arm,
    output logic [1:0] push
);
    logic turn;
    logic sel;
    logic fire;
    logic last;

    // Pick the armed circuit and decide whether it captures now.
    always_comb begin
        if (en == 2'b11)      sel = turn;
        else if (en == 2'b10) sel = 1'b1;
        else                  sel = 1'b0;
        fire = arm && !ctrl_we && en[sel] && hit[sel];
        push = fire ? (2'b01 << sel) : 2'b00;
        last = (en != 2'b11) || turn;
    end

    // Update the arm bit and the turn pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm  <= 1'b0;
            turn <= 1'b0;
        end else if (ctrl_we) begin
            arm <= ctrl_arm;
            if (!ctrl_arm) turn <= 1'b0;
        end else if (fire) begin
            if (last) begin
                turn <= 1'b0;
                if (oneshot) arm <= 1'b0;
            end else begin
                turn <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cap_fifo.sv
// Small capture FIFO with a word count and a sticky overflow flag.
// A push into a full FIFO is dropped and sets ovf. A pop when the
// FIFO is empty is ignored. clr_ovf clears the flag.
module cap_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          clr_ovf,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          ovf
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          full, take, drop;

    assign full = (count == CW'(DEPTH));
    assign take = push && !full;
    assign drop = pop && (count != '0);
    assign head = mem[rp];

    // Store accepted words.
    always_ff @(posedge clk) begin
        if (take) mem[wp] <= din;
    end

    // Move the pointers, the count and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (take) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (drop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(take) - CW'(drop);
            if (clr_ovf)          ovf <= 1'b0;
            else if (push && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/ping_pong_capture.sv
// Two-circuit input capture with ping-pong arming.
// Assumes sig_i is asynchronous and alt_evt_i is synchronous to clk.
// timer_i is sampled in the cycle a capture fires.
module ping_pong_capture #(
    parameter int TW    = 16,
    parameter int DEPTH = 4,
    parameter int WMW   = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic          ctrl_arm,
    input  logic          ctrl_oneshot,
    input  logic [1:0]    ctrl_edge0,
    input  logic [1:0]    ctrl_edge1,
    input  logic          ctrl_alt_sel,
    input  logic [WMW-1:0] ctrl_wmark,
    input  logic [TW-1:0] timer_i,
    input  logic          sig_i,
    input  logic          alt_evt_i,
    input  logic [1:0]    pop_i,
    output logic          arm_o,
    output logic [TW-1:0] head0_o,
    output logic [TW-1:0] head1_o,
    output logic [CW-1:0] cnt0_o,
    output logic [CW-1:0] cnt1_o,
    output logic [1:0]    wm_o,
    output logic [1:0]    ovf_o
);
    import cap_pkg::*;

    logic                 cfg_oneshot;
    logic                 cfg_alt;
    logic [WMW-1:0]       cfg_wmark;
    edge_sel_e            cfg_edge [2];
    logic                 sig_rise, sig_fall;
    logic [1:0]           cap_en, cap_hit, cap_push;
    logic [TW-1:0]        head [2];
    logic [CW-1:0]        cnt  [2];

    // Hold the mode fields loaded by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_oneshot <= 1'b0;
            cfg_alt     <= 1'b0;
            cfg_wmark   <= '0;
            cfg_edge[0] <= EDGE_OFF;
            cfg_edge[1] <= EDGE_OFF;
        end else if (ctrl_we) begin
            cfg_oneshot <= ctrl_oneshot;
            cfg_alt     <= ctrl_alt_sel;
            cfg_wmark   <= ctrl_wmark;
            cfg_edge[0] <= edge_sel_e'(ctrl_edge0);
            cfg_edge[1] <= edge_sel_e'(ctrl_edge1);
        end
    end

    cap_sync_edge #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(sig_i),
        .rise(sig_rise), .fall(sig_fall)
    );

    cap_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_arm(ctrl_arm),
        .oneshot(cfg_oneshot), .en(cap_en), .hit(cap_hit),
        .arm(arm_o), .push(cap_push)
    );

    for (genvar k = 0; k < 2; k++) begin : g_circ
        // Qualify events per circuit: alternate strobe or polarity match.
        always_comb begin
            cap_en[k]  = (cfg_edge[k] != EDGE_OFF);
            cap_hit[k] = cfg_alt ? alt_evt_i
                                 : edge_match(cfg_edge[k], sig_rise, sig_fall);
        end

        cap_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(cap_push[k]), .din(timer_i),
            .pop(pop_i[k]), .clr_ovf(ctrl_we),
            .head(head[k]), .count(cnt[k]), .ovf(ovf_o[k])
        );

        assign wm_o[k] = (cnt[k] > CW'(cfg_wmark));
    end

    assign head0_o = head[0];
    assign head1_o = head[1];
    assign cnt0_o  = cnt[0];
    assign cnt1_o  = cnt[1];
endmodule

// File: rtl/cap_checker.sv
// Temporal checks on the ping-pong capture block. Attached by bind.
// Assumes a synchronous active-low reset.
module cap_checker #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_we,
    input logic          arm,
    input logic          oneshot,
    input logic [1:0]    en,
    input logic [1:0]    push,
    input logic [CW-1:0] cnt0,
    input logic [CW-1:0] cnt1,
    input logic [1:0]    ovf
);
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt0 <= CW'(DEPTH)) && (cnt1 <= CW'(DEPTH)));

    assert_one_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push));

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 2'b00) |-> (push == 2'b00));

    assert_self_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arm) |-> ($past(ctrl_we) || $past(oneshot)));

    assert_no_growth_disarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> ((cnt0 <= $past(cnt0)) && (cnt1 <= $past(cnt1))));

    assert_ovf_sticky0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[0] && !ctrl_we) |=> ovf[0]);

    assert_ovf_sticky1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[1] && !ctrl_we) |=> ovf[1]);
endmodule

bind ping_pong_capture cap_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .arm(arm_o),
    .oneshot(cfg_oneshot), .en(cap_en), .push(cap_push),
    .cnt0(cnt0_o), .cnt1(cnt1_o), .ovf(ovf_o)
);

// File: tb/ping_pong_capture_tb.sv
// Scoreboard bench: drivers queue expected timestamps, a monitor drains
// the FIFOs and compares.
module ping_pong_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0, ctrl_arm = 1'b0, ctrl_oneshot = 1'b0, ctrl_alt_sel = 1'b0;
    logic [1:0]  ctrl_edge0 = 2'b00, ctrl_edge1 = 2'b00, ctrl_wmark = 2'b00;
    logic [15:0] timer_i = '0;
    logic        sig_i = 1'b0, alt_evt_i = 1'b0;
    logic [1:0]  pop_i = 2'b00;
    logic        arm_o;
    logic [15:0] head0_o, head1_o;
    logic [2:0]  cnt0_o, cnt1_o;
    logic [1:0]  wm_o, ovf_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_en   = 1'b0;
    int q0[$];
    int q1[$];

    always #5 clk = ~clk;

    ping_pong_capture u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_arm(ctrl_arm),
        .ctrl_oneshot(ctrl_oneshot), .ctrl_edge0(ctrl_edge0), .ctrl_edge1(ctrl_edge1),
        .ctrl_alt_sel(ctrl_alt_sel), .ctrl_wmark(ctrl_wmark), .timer_i(timer_i),
        .sig_i(sig_i), .alt_evt_i(alt_evt_i), .pop_i(pop_i), .arm_o(arm_o),
        .head0_o(head0_o), .head1_o(head1_o), .cnt0_o(cnt0_o), .cnt1_o(cnt1_o),
        .wm_o(wm_o), .ovf_o(ovf_o)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pop and compare each captured word against the scoreboard.
    always @(negedge clk) begin
        if (mon_en && cnt0_o != 0) begin
            if (q0.size() == 0) check_eq("R3 unexpected circuit 0 capture", int'(head0_o), -1);
            else check_eq("R2 circuit 0 timestamp", int'(head0_o), q0.pop_front());
            pop_i[0] = 1'b1;
        end else pop_i[0] = 1'b0;
        if (mon_en && cnt1_o != 0) begin
            if (q1.size() == 0) check_eq("R3 unexpected circuit 1 capture", int'(head1_o), -1);
            else check_eq("R2 circuit 1 timestamp", int'(head1_o), q1.pop_front());
            pop_i[1] = 1'b1;
        end else pop_i[1] = 1'b0;
    end

    task automatic ctrl_write(input logic arm, input logic os, input logic [1:0] e0,
                              input logic [1:0] e1, input logic alt, input logic [1:0] wm);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_arm = arm; ctrl_oneshot = os;
        ctrl_edge0 = e0; ctrl_edge1 = e1; ctrl_alt_sel = alt; ctrl_wmark = wm;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    // Driver: flip the line, hold the timer, queue the expected capture.
    task automatic toggle(input int tv, input int exp_circ);
        @(negedge clk);
        sig_i = ~sig_i;
        timer_i = 16'(tv);
        if (exp_circ == 0) q0.push_back(tv);
        if (exp_circ == 1) q1.push_back(tv);
        repeat (4) @(negedge clk);
    endtask

    task automatic alt_pulse(input int tv, input int exp_circ);
        @(negedge clk);
        alt_evt_i = 1'b1;
        timer_i = 16'(tv);
        if (exp_circ == 0) q0.push_back(tv);
        if (exp_circ == 1) q1.push_back(tv);
        @(negedge clk);
        alt_evt_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_drained(input string req);
        repeat (8) @(negedge clk);
        check_eq(req, q0.size() + q1.size(), 0);
        check_eq(req, int'(cnt0_o) + int'(cnt1_o), 0);
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 arm", int'(arm_o), 0);
        check_eq("R1 counts", int'(cnt0_o) + int'(cnt1_o), 0);
        check_eq("R1 flags", int'({wm_o, ovf_o}), 0);
        mon_en = 1'b1;

        // R2 polarity: both rising, falling edge ignored
        ctrl_write(1, 0, 2'b10, 2'b10, 0, 2'd3);
        toggle(100, 0); toggle(101, -1); toggle(102, 1); toggle(103, -1);
        check_drained("R2 rising only");

        // R3 ping-pong rising/falling, free-running
        ctrl_write(1, 0, 2'b10, 2'b01, 0, 2'd3);
        toggle(110, 0); toggle(111, 1); toggle(112, 0); toggle(113, 1);
        check_drained("R3 alternation");

        // R2 any edge
        ctrl_write(1, 0, 2'b11, 2'b11, 0, 2'd3);
        toggle(120, 0); toggle(121, 1);
        check_drained("R2 any edge");

        // R8 disarm stops captures and resets turn order
        ctrl_write(1, 0, 2'b11, 2'b11, 0, 2'd3);
        toggle(130, 0);
        ctrl_write(0, 0, 2'b11, 2'b11, 0, 2'd3);
        check_eq("R8 arm cleared", int'(arm_o), 0);
        toggle(131, -1);
        ctrl_write(1, 0, 2'b11, 2'b11, 0, 2'd3);
        toggle(132, 0);
        check_drained("R8 restart at circuit 0");

        // R4 one-shot with both circuits
        ctrl_write(0, 0, 2'b11, 2'b11, 0, 2'd3);
        ctrl_write(1, 1, 2'b11, 2'b11, 0, 2'd3);
        toggle(140, 0); toggle(141, 1);
        check_eq("R4 arm self-cleared", int'(arm_o), 0);
        toggle(142, -1);
        check_drained("R4 no capture after one-shot");

        // R5 circuit 1 alone, free-running
        ctrl_write(1, 0, 2'b00, 2'b11, 0, 2'd3);
        toggle(150, 1); toggle(151, 1); toggle(152, 1);
        check_eq("R5 arm stays set", int'(arm_o), 1);
        check_drained("R5 single circuit repeats");

        // R6 circuit 0 alone, one-shot
        ctrl_write(0, 0, 2'b11, 2'b00, 0, 2'd3);
        ctrl_write(1, 1, 2'b11, 2'b00, 0, 2'd3);
        toggle(160, 0);
        check_eq("R6 arm self-cleared", int'(arm_o), 0);
        toggle(161, -1);
        check_drained("R6 single capture");

        // R7 alternate source
        ctrl_write(1, 0, 2'b01, 2'b01, 1, 2'd3);
        alt_pulse(170, 0); alt_pulse(171, 1); toggle(172, -1);
        ctrl_write(1, 0, 2'b01, 2'b00, 1, 2'd3);
        alt_pulse(173, 0); alt_pulse(174, 0);
        ctrl_write(1, 0, 2'b00, 2'b00, 1, 2'd3);
        alt_pulse(175, -1);
        check_drained("R7 alternate events");

        // R9 / R10 fill, watermark, overflow
        ctrl_write(0, 0, 2'b00, 2'b00, 0, 2'd3);
        mon_en = 1'b0;
        ctrl_write(1, 0, 2'b11, 2'b00, 0, 2'd3);
        toggle(180, 0); toggle(181, 0); toggle(182, 0);
        check_eq("R9 count three", int'(cnt0_o), 3);
        check_eq("R10 wm clear at 3", int'(wm_o[0]), 0);
        toggle(183, 0);
        check_eq("R10 wm set at 4", int'(wm_o[0]), 1);
        toggle(184, -1);
        check_eq("R9 count full", int'(cnt0_o), 4);
        check_eq("R9 overflow set", int'(ovf_o[0]), 1);
        mon_en = 1'b1;
        check_drained("R9 drain after overflow");
        check_eq("R9 overflow sticky", int'(ovf_o[0]), 1);
        ctrl_write(0, 0, 2'b00, 2'b00, 0, 2'd0);
        check_eq("R9 overflow cleared by write", int'(ovf_o[0]), 0);

        ctrl_write(1, 0, 2'b11, 2'b00, 0, 2'd0);
        mon_en = 1'b0;
        toggle(185, 0);
        check_eq("R10 wm set at 1 over 0", int'(wm_o[0]), 1);
        mon_en = 1'b1;
        check_drained("R10 drain");

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule